// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

After every reset, this block reads a fixed 41-word image out of a three-wire serial EEPROM. The EEPROM interface has four pins: chip select, serial clock, data to the device and data from the device. The block runs a separate read command for each word, one word after another. The words go into three places:

- a bank of programmable configuration registers;
- a six-byte station-address store;
- a captured station-address checksum word.

While it reads, the block adds every image byte into an 8-bit running sum. When the last word has arrived, it judges the whole image. A good image sets the done and valid flags. A bad image clears both flags and puts every programmable register back to its default. The address store keeps the bytes it loaded.

Other logic in the chip reads the register bank and the address store straight from the ports. The `busy_o` output tells that logic when the contents are final. A new load starts only after a new reset.

Top module: `ee_cfg_loader`

## Requirements
- R1: While `rst_ni` is low, the outputs are: `busy_o`=1, `done_o`=0, `valid_o`=0, `ee_cs_o`=0, `stn_addr_o`=0, `stn_ck_o`=0, and configuration register k holds its default `16'hA500 | k`.
- R2: Each word read follows the same frame:
  - `ee_cs_o` goes high, then nine command bits go out on `ee_do_o`: 1, 1, 0, then a 6-bit word address, most significant bit first.
  - The device samples each command bit on a rising `ee_sk_o`. Sixteen data bits follow.
  - `ee_sk_o` rises once every 2*CLK_DIV clocks. It is high only while `ee_cs_o` is high.
  - Words are read at addresses 0 to 40 in rising order.
- R3: The first data bit received for a word lands in bit 15 of its destination. Each later bit fills the next lower bit.
- R4: Word w, for w from 9 to 40, is loaded into configuration register index w-5. So word 09h goes to register 4. Output element j of `cfg_o` is register 4+j.
- R5: The load passes when two conditions hold: the 8-bit modulo-256 sum of all 82 bytes equals FFh, and no word read as FFFFh. On a pass, `done_o` and `valid_o` become 1 and the registers keep the words that were loaded.
- R6: If the sum is not FFh, `done_o` and `valid_o` stay 0 and every configuration register returns to its default.
- R7: Station-address byte b, for b from 0 to 5, comes from word b/2. Even b takes bits 15:8 and odd b takes bits 7:0. Byte b appears at `stn_addr_o[8b+7:8b]`. These bytes are kept after both a pass and a fail.
- R8: A word that reads as FFFFh makes the load fail, even when the byte sum equals FFh. This covers a device that is absent and leaves the data line pulled high.
- R9: Word 6 (bytes 0Ch and 0Dh) appears as read on `stn_ck_o`. It has no effect on pass or fail.
- R10: `busy_o` stays high from reset until the check is complete, then stays low. Once the load has finished, `ee_cs_o` stays low until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_do_o | output | 1 | Command bits to EEPROM |
| ee_di_i | input | 1 | Data bits from EEPROM |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load completed with a good image |
| valid_o | output | 1 | Image contents valid |
| cfg_o | output | 32x16 | Configuration registers 4..35 (element j = register 4+j) |
| stn_addr_o | output | 48 | Station-address bytes 0..5 |
| stn_ck_o | output | 16 | Station-address checksum word as read |

## Verification
The verdict is due on the clock edge that follows the last word's completion. At that same edge, `busy_o` falls and `done_o`, `valid_o` and any restored defaults take effect. The bench therefore polls `busy_o` at falling clock edges and samples every result on the first falling edge at which `busy_o` reads low. Serial timing is checked against the device's own view of the wire. An EEPROM model records each rising `ee_sk_o`, checks the command bits and the address sequence, and drives each data bit on a rising edge. That drive happens 2*CLK_DIV/2 clocks before the loader samples the bit, at the end of the high half-period. The idle check after completion runs for 64 further clocks.

// File: rtl/ee_ldr_pkg.sv
package ee_ldr_pkg;
  typedef enum logic [1:0] {LD_ISSUE, LD_WAIT, LD_CHECK, LD_DONE} ld_state_e;
  typedef enum logic [1:0] {MW_IDLE, MW_SHIFT, MW_GAP} mw_state_e;

  function automatic logic [15:0] cfg_default(int unsigned idx);
    return 16'hA500 | 16'(idx & 32'hFF);
  endfunction
endpackage

// File: rtl/ee_mw_shifter.sv
module ee_mw_shifter
  import ee_ldr_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              idle_o,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              do_o,
  input  logic              di_i
);
  localparam int CMD_W = 3 + ADDR_W;
  localparam int TOT   = CMD_W + DATA_W;
  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam int BIT_W = $clog2(TOT + 1);

  mw_state_e         state_q;
  logic [DIV_W-1:0]  div_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              tick;

  assign tick   = (div_q == DIV_W'(CLK_DIV - 1));
  assign idle_o = (state_q == MW_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MW_IDLE;
      div_q   <= '0;
      bit_q   <= '0;
      cmd_q   <= '0;
      word_o  <= '0;
      cs_o    <= 1'b0;
      sk_o    <= 1'b0;
      do_o    <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        MW_IDLE: if (start_i) begin
          state_q <= MW_SHIFT;
          cmd_q   <= {3'b110, addr_i};
          do_o    <= 1'b1;
          cs_o    <= 1'b1;
          bit_q   <= '0;
          div_q   <= '0;
        end
        MW_SHIFT: if (!tick) div_q <= div_q + 1'b1;
        else begin
          div_q <= '0;
          if (!sk_o) sk_o <= 1'b1;
          else begin
            sk_o <= 1'b0;
            // data is sampled at the end of the high half-period
            if (bit_q >= BIT_W'(CMD_W)) word_o <= {word_o[DATA_W-2:0], di_i};
            if (bit_q == BIT_W'(TOT - 1)) begin
              state_q <= MW_GAP;
              cs_o    <= 1'b0;
              do_o    <= 1'b0;
            end else begin
              bit_q <= bit_q + 1'b1;
              cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
              do_o  <= (bit_q < BIT_W'(CMD_W - 1)) ? cmd_q[CMD_W-2] : 1'b0;
            end
          end
        end
        MW_GAP: if (!tick) div_q <= div_q + 1'b1;
        else begin
          div_q   <= '0;
          state_q <= MW_IDLE;
          done_o  <= 1'b1;
        end
        default: state_q <= MW_IDLE;
      endcase
    end
  end

  p_sk_needs_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> cs_o);
  p_done_deselected_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cs_o);
endmodule

// File: rtl/ee_img_sum.sv
module ee_img_sum #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [7:0]        sum_o,
  output logic              ones_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o  <= '0;
      ones_o <= 1'b0;
    end else if (vld_i) begin
      sum_o  <= sum_o + word_i[15:8] + word_i[7:0];
      if (&word_i) ones_o <= 1'b1;
    end
  end

  p_ones_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_o |=> ones_o);
endmodule

// File: rtl/ee_cfg_regs.sv
module ee_cfg_regs
  import ee_ldr_pkg::*;
#(
  parameter int N_CFG    = 32,
  parameter int BASE_IDX = 4,
  parameter int SEL_W    = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [SEL_W-1:0]       sel_i,
  input  logic [15:0]            data_i,
  input  logic                   restore_i,
  output logic [N_CFG-1:0][15:0] cfg_o
);
  for (genvar j = 0; j < N_CFG; j++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cfg_o[j] <= cfg_default(BASE_IDX + j);
      else if (restore_i)                       cfg_o[j] <= cfg_default(BASE_IDX + j);
      else if (wr_i && sel_i == SEL_W'(j))      cfg_o[j] <= data_i;
    end
  end
endmodule

// File: rtl/ee_cfg_loader.sv
module ee_cfg_loader
  import ee_ldr_pkg::*;
#(
  parameter int N_WORDS   = 41,
  parameter int ADDR_W    = 6,
  parameter int CLK_DIV   = 2,
  parameter int CFG_WORD0 = 9,
  parameter int CFG_IDX0  = 4,
  parameter int STN_BYTES = 6,
  parameter int STN_CK_W  = 6,
  localparam int N_CFG    = N_WORDS - CFG_WORD0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  output logic                   ee_cs_o,
  output logic                   ee_sk_o,
  output logic                   ee_do_o,
  input  logic                   ee_di_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   valid_o,
  output logic [N_CFG-1:0][15:0] cfg_o,
  output logic [8*STN_BYTES-1:0] stn_addr_o,
  output logic [15:0]            stn_ck_o
);
  localparam int IDX_W = $clog2(N_WORDS);

  ld_state_e        state_q;
  logic [IDX_W-1:0] widx_q;
  logic             mw_idle, w_done, start, pass, restore, cfg_wr, ones;
  logic [15:0]      word;
  logic [7:0]       sum;
  logic [IDX_W-1:0] cfg_sel;

  assign start   = (state_q == LD_ISSUE) && mw_idle;
  assign pass    = (sum == 8'hFF) && !ones;
  assign restore = (state_q == LD_CHECK) && !pass;
  assign cfg_wr  = w_done && (widx_q >= IDX_W'(CFG_WORD0));
  assign cfg_sel = widx_q - IDX_W'(CFG_WORD0);
  assign busy_o  = (state_q != LD_DONE);

  ee_mw_shifter #(.CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W), .DATA_W(16)) i_shift (
    .clk_i, .rst_ni, .start_i(start), .addr_i(ADDR_W'(widx_q)),
    .idle_o(mw_idle), .done_o(w_done), .word_o(word),
    .cs_o(ee_cs_o), .sk_o(ee_sk_o), .do_o(ee_do_o), .di_i(ee_di_i)
  );

  ee_img_sum #(.DATA_W(16)) i_sum (
    .clk_i, .rst_ni, .vld_i(w_done), .word_i(word), .sum_o(sum), .ones_o(ones)
  );

  ee_cfg_regs #(.N_CFG(N_CFG), .BASE_IDX(CFG_IDX0), .SEL_W(IDX_W)) i_regs (
    .clk_i, .rst_ni, .wr_i(cfg_wr), .sel_i(cfg_sel), .data_i(word),
    .restore_i(restore), .cfg_o(cfg_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= LD_ISSUE;
      widx_q     <= '0;
      done_o     <= 1'b0;
      valid_o    <= 1'b0;
      stn_addr_o <= '0;
      stn_ck_o   <= '0;
    end else begin
      unique case (state_q)
        LD_ISSUE: if (mw_idle) state_q <= LD_WAIT;
        LD_WAIT: if (w_done) begin
          for (int b = 0; b < STN_BYTES; b++)
            if (widx_q == IDX_W'(b / 2))
              stn_addr_o[8*b +: 8] <= (b % 2 == 0) ? word[15:8] : word[7:0];
          if (widx_q == IDX_W'(STN_CK_W)) stn_ck_o <= word;
          if (widx_q == IDX_W'(N_WORDS - 1)) state_q <= LD_CHECK;
          else begin
            widx_q  <= widx_q + 1'b1;
            state_q <= LD_ISSUE;
          end
        end
        LD_CHECK: begin
          done_o  <= pass;
          valid_o <= pass;
          state_q <= LD_DONE;
        end
        default: state_q <= LD_DONE;
      endcase
    end
  end

  p_busy_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !busy_o);
  p_quiet_after_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ee_cs_o);
  p_valid_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> done_o);
  p_pass_sum_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (sum == 8'hFF));
  p_restore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !valid_o) |-> (cfg_o[0] == cfg_default(CFG_IDX0)));
endmodule

// File: tb/test_ee_cfg_loader.sv
module test_ee_cfg_loader;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cs, sk, dout, busy, done, valid;
  logic di = 1'b1;
  logic [31:0][15:0] cfg;
  logic [47:0] stn_addr;
  logic [15:0] stn_ck;

  ee_cfg_loader i_ee_cfg_loader (
    .clk_i(clk), .rst_ni(rst_n), .ee_cs_o(cs), .ee_sk_o(sk), .ee_do_o(dout),
    .ee_di_i(di), .busy_o(busy), .done_o(done), .valid_o(valid),
    .cfg_o(cfg), .stn_addr_o(stn_addr), .stn_ck_o(stn_ck)
  );

  logic [15:0] mem [0:63];
  int n_chk = 0, n_bad = 0;

  // EEPROM model
  int bitn = 0, words_n = 0, cmd_err = 0, rises = 0;
  logic [8:0] cmd;
  logic [15:0] cur;
  time t_r1, t_r2;
  always @(posedge sk or negedge cs or negedge rst_n) begin
    if (!rst_n) begin
      words_n = 0; cmd_err = 0; rises = 0; bitn = 0;
    end else if (!cs) bitn = 0;
    else begin
      rises++;
      if (rises == 1) t_r1 = $time;
      if (rises == 2) t_r2 = $time;
      if (bitn < 9) cmd = {cmd[7:0], dout};
      else begin
        if (bitn == 9) begin
          if (cmd[8:6] != 3'b110 || cmd[5:0] != 6'(words_n)) cmd_err++;
          cur = mem[cmd[5:0]];
          words_n++;
        end
        di = cur[15 - (bitn - 9)];
      end
      bitn++;
    end
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // mode: 0 good, 1 sum corrupted, 2 FFFF word with good sum, 3 no device
  task automatic build(logic [7:0] seed, logic [1:0] mode);
    logic [7:0] s;
    for (int w = 0; w < 64; w++) mem[w] = 16'hFFFF;
    if (mode == 3) return;
    for (int w = 0; w < 41; w++)
      mem[w] = {8'(seed * 3 + w * 10 + 1) & 8'h7F, 8'(seed * 11 + w * 14 + 10)};
    if (mode == 2) mem[20] = 16'hFFFF;
    s = 8'h00;
    for (int w = 0; w < 40; w++) s = s + mem[w][15:8] + mem[w][7:0];
    mem[40] = {8'h00, 8'hFF - s};
    if (mode == 1) mem[12] = mem[12] ^ 16'h0100;
  endtask

  localparam logic [10:0] VEC [5] = '{
    {8'h11, 2'd0, 1'b1}, {8'h5A, 2'd0, 1'b1}, {8'h23, 2'd1, 1'b0},
    {8'h37, 2'd2, 1'b0}, {8'h00, 2'd3, 1'b0}
  };

  task automatic run_case(logic [7:0] seed, logic [1:0] mode, logic exp);
    logic [47:0] ea;
    logic [7:0]  sc;
    int hi;
    rst_n = 1'b0;
    build(seed, mode);
    repeat (3) @(negedge clk);
    chk(busy && !done && !valid && !cs, "R1 flags in reset", {busy, done, valid, cs}, 4'b1000);
    chk(cfg[5] == 16'hA509, "R1 cfg default", cfg[5], 16'hA509);
    chk(stn_addr == 0 && stn_ck == 0, "R1 address store clear", stn_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy, "R10 busy after reset release", busy, 1);
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    chk(!busy, "R10 load finished", busy, 0);
    chk(done == exp, mode == 2 ? "R8 done" : (exp ? "R5 done" : "R6 done"), done, exp);
    chk(valid == exp, mode == 2 ? "R8 valid" : (exp ? "R5 valid" : "R6 valid"), valid, exp);
    chk(cfg[0] == (exp ? mem[9] : 16'hA504), "R3 R4 word 09h into register 4", cfg[0],
        exp ? mem[9] : 16'hA504);
    for (int j = 1; j < 32; j++)
      chk(cfg[j] == (exp ? mem[9 + j] : 16'hA500 | 16'(4 + j)),
          exp ? "R4 cfg register" : "R6 cfg restored", cfg[j],
          exp ? mem[9 + j] : 16'hA500 | 16'(4 + j));
    for (int b = 0; b < 6; b++) ea[8*b +: 8] = (b % 2 == 0) ? mem[b/2][15:8] : mem[b/2][7:0];
    chk(stn_addr == ea, "R7 station address kept", stn_addr, ea);
    chk(stn_ck == mem[6], "R9 station checksum word", stn_ck, mem[6]);
    if (mode == 0) begin
      sc = 8'h00;
      for (int b = 0; b < 16; b++)
        if (b != 12 && b != 13) sc = sc + ((b % 2 == 0) ? mem[b/2][15:8] : mem[b/2][7:0]);
      chk({sc, sc} != mem[6] && valid, "R9 station checksum not enforced", mem[6], {sc, sc});
    end
    chk(cmd_err == 0 && words_n == 41, "R2 command frames and order", {cmd_err, words_n}, 41);
    chk(t_r2 - t_r1 == 40, "R2 serial clock period", t_r2 - t_r1, 40);
    hi = 0;
    repeat (64) begin @(negedge clk); if (cs) hi++; end
    chk(hi == 0 && words_n == 41 && !busy, "R10 idle after load", hi, 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    foreach (VEC[k]) run_case(VEC[k][10:3], VEC[k][2:1], VEC[k][0]);
    // directed: corrupt the adjust byte only
    run_case(8'h42, 2'd0, 1'b1);
    mem[40] = mem[40] ^ 16'h0001;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    chk(!valid && !done, "R6 adjust byte wrong", {done, valid}, 0);
    chk(cfg[31] == 16'hA523, "R6 last register restored", cfg[31], 16'hA523);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule